// File: doc/BRIEF.md
# Cross-Clock Register Write Bridge

This block lets a bus-clocked host write a small register file that runs on its own, unrelated clock. A write is captured in the bus domain. Its address and data are then held steady while a toggle request crosses into the register domain through a two-flop synchronizer. The register domain applies the write and returns a toggle acknowledge through a second synchronizer.

The bus is never stalled. A status output, `wr_done_o`, drops on the edge that accepts a write and rises again only after the register domain has applied it. Software must see this bit high before it starts another write, or a read that follows a write. A write issued while the bit is low is discarded and raises a sticky error flag.

Reads come from a bus-domain shadow copy. The shadow is refreshed when the acknowledge returns, so any number of reads may be issued back to back in any cycle.

Top module: `cdc_wr_bridge`

## Requirements
- R1: After reset, `wr_done_o` is 1, `wr_err_o` is 0, `per_wr_o` is 0, and every register reads 0 on both `rd_data_o` and `per_regs_o`.
- R2: A write accepted while `wr_done_o` is 1 (`wr_en_i` high at a rising `clk_i` edge) makes `wr_done_o` read 0 from that edge on.
- R3: After an accepted write, `wr_done_o` returns to 1 only after the write has taken effect in the `pclk_i` domain. This happens within 4 `pclk_i` periods plus 4 `clk_i` periods.
- R4: Each accepted write produces exactly one `per_wr_o` pulse, one `pclk_i` cycle long. During that pulse `per_addr_o` and `per_data_o` carry the address and data of the write.
- R5: After an accepted write lands, register `a` holds the written data in `per_regs_o[a*DW +: DW]`. All other registers keep their values.
- R6: A write issued while `wr_done_o` is 0 is ignored. It produces no `per_wr_o` pulse, changes no register, and sets `wr_err_o` on the next `clk_i` edge.
- R7: `wr_err_o` is sticky. Once set, it stays 1 through later accepted writes until reset.
- R8: `rd_data_o` shows the last completed value of register `rd_addr_i` combinationally, in any cycle. Reads on consecutive cycles need no spacing and do not affect `wr_done_o`.
- R9: While a write is pending (`wr_done_o` 0), `rd_data_o` for the target address still shows the old value. It changes only on the edge where `wr_done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| pclk_i | input | 1 | Register-domain clock, unrelated to clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_en_i | input | 1 | Write request, bus domain |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Shadowed register value for rd_addr_i |
| wr_done_o | output | 1 | 1 when the next access is safe |
| wr_err_o | output | 1 | Sticky flag: a write arrived while busy |
| per_wr_o | output | 1 | One-cycle write strobe, pclk_i domain |
| per_addr_o | output | AW | Address applied, pclk_i domain |
| per_data_o | output | DW | Data applied, pclk_i domain |
| per_regs_o | output | NREG*DW | Register file contents, pclk_i domain |

## Verification
The drop of `wr_done_o` and the rise of `wr_err_o` are both due exactly one `clk_i` edge after the stimulus. The bench checks them at the following falling edge of `clk_i`.

The return of `wr_done_o` depends on two unrelated clocks, so the bench polls it at each falling `clk_i` edge within the R3 bound. It then checks the register file, the read port and the write-strobe count in the same sample.

Strobes are counted by a monitor at the falling edge of `pclk_i`. A few extra `pclk_i` cycles are waited before the count is compared, so a duplicate strobe would also be caught.

// File: rtl/cdc_wr_pkg.sv
package cdc_wr_pkg;
  localparam int unsigned DEF_AW = 2;
  localparam int unsigned DEF_DW = 32;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int unsigned STAGES = cdc_wr_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cdc_wr_bus_side.sv
module cdc_wr_bus_side #(
  parameter int unsigned AW = cdc_wr_pkg::DEF_AW,
  parameter int unsigned DW = cdc_wr_pkg::DEF_DW,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_done_o,
  output logic          wr_err_o,
  output logic          req_tgl_o,
  output logic [AW-1:0] hold_addr_o,
  output logic [DW-1:0] hold_data_o,
  input  logic          ack_tgl_i
);
  logic          done_q, err_q, req_q, ack_seen_q, ack_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] shadow_q [NREG];
  logic          accept, ack_new;

  cdc_sync i_ack_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_tgl_i), .q_o(ack_s));

  assign accept  = wr_en_i && done_q;
  assign ack_new = ack_s != ack_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b1;
      err_q      <= 1'b0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      if (accept) begin
        addr_q <= wr_addr_i;
        data_q <= wr_data_i;
        req_q  <= ~req_q;
        done_q <= 1'b0;
      end else if (ack_new) begin
        ack_seen_q <= ack_s;
        done_q     <= 1'b1;
      end
      if (wr_en_i && !done_q) err_q <= 1'b1;
    end
  end

  // shadow refresh: held data is stable until the ack lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) shadow_q[i] <= '0;
    end else if (ack_new && !done_q) begin
      shadow_q[addr_q] <= data_q;
    end
  end

  assign rd_data_o   = shadow_q[rd_addr_i];
  assign wr_done_o   = done_q;
  assign wr_err_o    = err_q;
  assign req_tgl_o   = req_q;
  assign hold_addr_o = addr_q;
  assign hold_data_o = data_q;
endmodule

// File: rtl/cdc_wr_per_side.sv
module cdc_wr_per_side #(
  parameter int unsigned AW = cdc_wr_pkg::DEF_AW,
  parameter int unsigned DW = cdc_wr_pkg::DEF_DW,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic             pclk_i,
  input  logic             rst_ni,
  input  logic             req_tgl_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic             ack_tgl_o,
  output logic             per_wr_o,
  output logic [AW-1:0]    per_addr_o,
  output logic [DW-1:0]    per_data_o,
  output logic [NREG*DW-1:0] per_regs_o
);
  logic          req_s, seen_q, wr_q;
  logic [AW-1:0] paddr_q;
  logic [DW-1:0] pdata_q;
  logic [DW-1:0] regs_q [NREG];
  logic          req_new;

  cdc_sync i_req_sync (.clk_i(pclk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_s));

  assign req_new = req_s != seen_q;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      wr_q    <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      wr_q <= req_new;
      if (req_new) begin
        seen_q         <= req_s;
        paddr_q        <= addr_i;
        pdata_q        <= data_i;
        regs_q[addr_i] <= data_i;
      end
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign per_regs_o[g*DW +: DW] = regs_q[g];
    end
  endgenerate

  assign ack_tgl_o  = seen_q;
  assign per_wr_o   = wr_q;
  assign per_addr_o = paddr_q;
  assign per_data_o = pdata_q;
endmodule

// File: rtl/cdc_wr_bridge.sv
module cdc_wr_bridge #(
  parameter int unsigned AW = cdc_wr_pkg::DEF_AW,
  parameter int unsigned DW = cdc_wr_pkg::DEF_DW,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic               clk_i,
  input  logic               pclk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic               wr_done_o,
  output logic               wr_err_o,
  output logic               per_wr_o,
  output logic [AW-1:0]      per_addr_o,
  output logic [DW-1:0]      per_data_o,
  output logic [NREG*DW-1:0] per_regs_o
);
  logic          req_tgl, ack_tgl;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;

  cdc_wr_bus_side #(.AW(AW), .DW(DW)) i_bus (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wr_done_o(wr_done_o), .wr_err_o(wr_err_o),
    .req_tgl_o(req_tgl), .hold_addr_o(hold_addr), .hold_data_o(hold_data),
    .ack_tgl_i(ack_tgl)
  );

  cdc_wr_per_side #(.AW(AW), .DW(DW)) i_per (
    .pclk_i(pclk_i), .rst_ni(rst_ni),
    .req_tgl_i(req_tgl), .addr_i(hold_addr), .data_i(hold_data),
    .ack_tgl_o(ack_tgl),
    .per_wr_o(per_wr_o), .per_addr_o(per_addr_o), .per_data_o(per_data_o),
    .per_regs_o(per_regs_o)
  );
endmodule

// File: rtl/cdc_wr_bridge_chk.sv
module cdc_wr_bridge_chk #(
  parameter int unsigned AW = cdc_wr_pkg::DEF_AW,
  parameter int unsigned DW = cdc_wr_pkg::DEF_DW,
  localparam int unsigned NREG = 1 << AW
) (
  input logic               clk_i,
  input logic               pclk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [AW-1:0]      wr_addr_i,
  input logic [DW-1:0]      wr_data_i,
  input logic [AW-1:0]      rd_addr_i,
  input logic [DW-1:0]      rd_data_o,
  input logic               wr_done_o,
  input logic               wr_err_o,
  input logic               per_wr_o,
  input logic [AW-1:0]      per_addr_o,
  input logic [DW-1:0]      per_data_o,
  input logic [NREG*DW-1:0] per_regs_o
);
  // R2
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_done_o) |=> !wr_done_o);

  // R6
  busy_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_done_o) |=> wr_err_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> wr_err_o);

  // R4
  strobe_single_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    per_wr_o |=> !per_wr_o);

  // R5
  strobe_reg_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    per_wr_o |-> per_regs_o[per_addr_o*DW +: DW] == per_data_o);

  // R9
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_addr_i) && !$rose(wr_done_o)) |-> $stable(rd_data_o));
endmodule

bind cdc_wr_bridge cdc_wr_bridge_chk #(.AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_cdc_wr_bridge.sv
module test_cdc_wr_bridge;
  localparam int AW = 2;
  localparam int DW = 32;
  localparam int NREG = 1 << AW;
  localparam int POLL_MAX = 40;

  logic clk = 1'b0, pclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic done, err, per_wr;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_data;
  logic [NREG*DW-1:0] per_regs;

  int n_chk = 0, n_bad = 0;
  int strobes = 0;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;
  logic [DW-1:0] model [NREG];
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always #6.85 pclk = ~pclk;

  cdc_wr_bridge #(.AW(AW), .DW(DW)) i_cdc_wr_bridge (
    .clk_i(clk), .pclk_i(pclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_done_o(done), .wr_err_o(err),
    .per_wr_o(per_wr), .per_addr_o(per_addr), .per_data_o(per_data),
    .per_regs_o(per_regs)
  );

  always @(negedge pclk) if (per_wr) begin
    strobes++;
    last_addr = per_addr;
    last_data = per_data;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < POLL_MAX) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    check("R1 done", done, 1);
    check("R1 err", err, 0);
    check("R1 strobe", per_wr, 0);
    for (int i = 0; i < NREG; i++) begin
      rd_addr = i[AW-1:0];
      #1;
      check("R1 rd", rd_data, 0);
      check("R1 regs", per_regs[i*DW +: DW], 0);
    end
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int s0, cyc;
    s0 = strobes;
    rd_addr = a;
    issue(a, d);
    check("R2 done low", done, 0);
    check("R9 old value", rd_data, model[a]);
    wait_done(cyc);
    check("R3 done back", done, 1);
    check("R3 landed first", strobes, s0 + 1);
    model[a] = d;
    repeat (4) @(negedge pclk);
    @(negedge clk);
    check("R4 one strobe", strobes, s0 + 1);
    check("R4 addr", last_addr, a);
    check("R4 data", last_data, d);
    for (int i = 0; i < NREG; i++)
      check("R5 regs", per_regs[i*DW +: DW], model[i]);
    check("R8 rd", rd_data, d);
  endtask

  task automatic t_busy;
    int s0, cyc;
    s0 = strobes;
    issue(2'd1, 32'hAAAA_0001);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'hBAD0_BAD0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 err set", err, 1);
    wait_done(cyc);
    model[1] = 32'hAAAA_0001;
    repeat (4) @(negedge pclk);
    @(negedge clk);
    check("R6 one strobe", strobes, s0 + 1);
    check("R6 reg3 kept", per_regs[3*DW +: DW], model[3]);
    check("R6 reg1", per_regs[1*DW +: DW], model[1]);
  endtask

  task automatic t_sticky;
    t_write(2'd0, 32'h0F0F_1234);
    check("R7 err sticky", err, 1);
  endtask

  task automatic t_reads;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rd_addr = k[AW-1:0];
      #1;
      check("R8 b2b read", rd_data, model[k % NREG]);
      check("R8 done kept", done, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_write(2'd2, 32'hDEAD_BEEF);
    t_write(2'd0, 32'h1234_5678);
    t_write(2'd2, 32'h0000_0001);
    t_write(2'd3, 32'hFFFF_FFFF);
    t_busy;
    t_sticky;
    t_reads;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule